// File: doc/BRIEF.md
# Condition Code Flag Evaluator

This block derives the condition flags of a processor's most recent operation and folds them into the condition code status word. The caller presents the operation class, the operand size, both operands, the result and, for multiplies, the upper product word, together with the current extended-arithmetic (X) flag, a flag-update mask and the old status word. The block returns the new status word in the same cycle.

Carry and overflow come from the sign bits of the two operands and the result, not from an adder. Subtraction reuses the addition rules with the source sign inverted and the carry inverted afterwards. One variant of the carry-propagating add reports its carry in a separate R flag. Multiplies judge the whole 64-bit product. A bit-test operation reports one chosen bit of a word and whether that bit and everything below it is zero. Every update clears X. While X is set, a zero result can leave Z alone but cannot set it, so chained wide arithmetic keeps a correct Z.

Top module: `ccf_eval`

## Requirements
- R1: Size code 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. Sign tests use bit 7, 15 or 31 and zero tests look only at the low 8, 16 or 32 result bits. Size code 3 produces no flags in the add, subtract and carry-propagate classes.
- R2: Add class (op 0, and reserved op 7): when the result sign is set, N is set. V is set if both operand signs are clear, and C is set if both are set. Z is clear in this case.
- R3: Add class with a clear result sign: Z is set when the sized result is zero, V is set when both operand signs are set, and C is set when either operand sign is set. N is clear.
- R4: Subtract/compare (op 1) applies the R2/R3 rules with the source sign inverted, then inverts C.
- R5: Carry-propagating add (op 3) follows R2/R3 but raises R (bit 8) where the add class would raise C. C stays clear in its flag set.
- R6: Move/logic/shift (op 2) at sizes 2 and 4 sets only N from the result sign, or Z from a zero sized result. At size 1 it follows the add rules (R2/R3).
- R7: Signed multiply (op 4): {mof,res} sets Z if all 64 bits are zero and N if bit 63 is set. V is set when mof differs from 32 copies of res bit 31.
- R8: Unsigned multiply (op 5): Z is set when the 64-bit value is zero, N equals bit 63, and V is set when mof is nonzero.
- R9: For every class except bit test, the write mask is update-mask OR the X bit. Masked status bits take the computed flags, all other bits keep their old value, and X always leaves at 0.
- R10: When X is set and the computed Z is 1, Z is removed from the write mask, so the old Z is kept. A computed Z of 0 still clears Z if the mask covers it.
- R11: Bit test (op 6) reads bit src[4:0] of dst. N takes that bit, and Z is set when that bit and all bits below it are zero.
- R12: Bit test clears X, N and Z, and also clears V and C when the version input is below 32. It ignores the update mask and leaves every other status bit unchanged.
- R13: Flag positions in the status word: C bit 0, V bit 1, Z bit 2, N bit 3, X bit 4, R bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation class (0 add, 1 sub/cmp, 2 move/logic/shift, 3 carry-propagating add, 4 signed mul, 5 unsigned mul, 6 bit test, 7 treated as add) |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Source operand (bit index for bit test) |
| dst_i | input | 32 | Destination operand (tested word for bit test) |
| res_i | input | 32 | Operation result (low product word for multiplies) |
| mof_i | input | 32 | Upper product word |
| x_i | input | 1 | X flag in effect for the operation |
| upd_mask_i | input | 32 | Flags the operation may update |
| ccs_i | input | 32 | Old status word |
| ver_i | input | 8 | Core version number |
| ccs_o | output | 32 | New status word |

## Verification
The evaluator holds no state, so every result is due in the same cycle as its inputs. The bench changes inputs just after a rising edge and compares ccs_o at the following falling edge, half a period later, when no input is moving. Each vector is checked once at that point, so no result is ever read across an edge.

// File: rtl/ccf_pkg.sv
// Shared types and flag positions for the condition code evaluator.
package ccf_pkg;
    localparam int FB_C = 0;
    localparam int FB_V = 1;
    localparam int FB_Z = 2;
    localparam int FB_N = 3;
    localparam int FB_X = 4;
    localparam int FB_R = 8;
    localparam int VER_GATE = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MOVE = 3'd2,
        OP_MCP  = 3'd3,
        OP_MULS = 3'd4,
        OP_MULU = 3'd5,
        OP_BTST = 3'd6,
        OP_RSVD = 3'd7
    } ccf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } ccf_size_e;

    typedef struct packed {
        logic r;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccf_flags_t;
endpackage

// File: rtl/ccf_sign_pick.sv
// Picks the sign bit and the zero test of a value at the selected operand size.
// Assumes DATA_W is a multiple of 4; lane widths are DATA_W/4, /2 and full.
module ccf_sign_pick #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [1:0]        size_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              valid_o
);
    localparam int LANES = 3;

    logic [LANES-1:0] lane_sign;
    logic [LANES-1:0] lane_zero;

    // One lane per supported size: top bit and low-part zero test.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (DATA_W / 4) << g;
        assign lane_sign[g] = val_i[LW-1];
        assign lane_zero[g] = ~|val_i[LW-1:0];
    end

    // Select the lane named by the size code; code 3 is not a valid size.
    always_comb begin
        valid_o = (size_i != 2'd3);
        sign_o  = 1'b0;
        zero_o  = 1'b0;
        if (valid_o) begin
            sign_o = lane_sign[size_i];
            zero_o = lane_zero[size_i];
        end
    end
endmodule

// File: rtl/ccf_arith_eval.sv
// Sign-bit flag rules for add, subtract and carry-propagating add.
// Assumes res_i is the result of the operation on src_i and dst_i.
module ccf_arith_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        size_i,
    input  logic              is_sub_i,
    input  logic              is_mcp_i,
    output ccf_flags_t        flags_o,
    output logic              res_sign_o,
    output logic              res_zero_o
);
    logic s_sign, s_zero, s_valid;
    logic d_sign, d_zero, d_valid;
    logic r_valid;
    logic a_sign;
    logic carry_raw;
    logic unused_side;

    ccf_sign_pick #(.DATA_W(DATA_W)) u_src (
        .val_i(src_i), .size_i(size_i),
        .sign_o(s_sign), .zero_o(s_zero), .valid_o(s_valid)
    );
    ccf_sign_pick #(.DATA_W(DATA_W)) u_dst (
        .val_i(dst_i), .size_i(size_i),
        .sign_o(d_sign), .zero_o(d_zero), .valid_o(d_valid)
    );
    ccf_sign_pick #(.DATA_W(DATA_W)) u_res (
        .val_i(res_i), .size_i(size_i),
        .sign_o(res_sign_o), .zero_o(res_zero_o), .valid_o(r_valid)
    );

    assign unused_side = ^{s_zero, d_zero, s_valid, d_valid};
    assign a_sign      = s_sign ^ is_sub_i;

    // Apply the two-branch sign rules, then route the carry to C or R.
    always_comb begin
        flags_o   = '0;
        carry_raw = 1'b0;
        if (r_valid) begin
            if (res_sign_o) begin
                flags_o.n = 1'b1;
                flags_o.v = ~a_sign & ~d_sign;
                carry_raw = a_sign & d_sign;
            end else begin
                flags_o.z = res_zero_o;
                flags_o.v = a_sign & d_sign;
                carry_raw = a_sign | d_sign;
            end
            if (is_mcp_i) begin
                flags_o.r = carry_raw;
            end else begin
                flags_o.c = carry_raw ^ is_sub_i;
            end
        end
    end

    // N and Z come from opposite branches and never appear together.
    always_comb begin
        AST_ARITH_NZ_EXCL: assert (!(flags_o.n && flags_o.z)) else $error("N and Z both set"); // R2
    end
    // The carry-propagating add never reports C.
    always_comb begin
        AST_MCP_NO_C: assert (!(is_mcp_i && flags_o.c)) else $error("C raised in MCP"); // R5
    end
endmodule

// File: rtl/ccf_mul_eval.sv
// Flag rules for the 64-bit product {mof,res} of signed or unsigned multiply.
module ccf_mul_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] mof_i,
    input  logic              signed_i,
    output ccf_flags_t        flags_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] prod;

    assign prod = {mof_i, res_i};

    // Zero and sign of the full product; overflow by mode.
    always_comb begin
        flags_o   = '0;
        flags_o.z = ~|prod;
        flags_o.n = prod[PROD_W-1];
        if (signed_i) begin
            flags_o.v = (mof_i != {DATA_W{res_i[DATA_W-1]}});
        end else begin
            flags_o.v = |mof_i;
        end
    end

    // A zero product cannot overflow in either mode.
    always_comb begin
        AST_MUL_ZERO_NO_V: assert (!(flags_o.z && flags_o.v)) else $error("zero product with V"); // R7
    end
endmodule

// File: rtl/ccf_writeback.sv
// Merges computed flags into the status word under the update mask.
// X is always part of the mask; with X set a computed Z is withheld.
module ccf_writeback
    import ccf_pkg::*;
#(
    parameter int CCS_W = 32
) (
    input  ccf_flags_t        flags_i,
    input  logic              x_i,
    input  logic [CCS_W-1:0]  upd_mask_i,
    input  logic [CCS_W-1:0]  ccs_i,
    output logic [CCS_W-1:0]  ccs_o
);
    logic [CCS_W-1:0] placed;
    logic [CCS_W-1:0] wmask;

    // Place each flag at its status bit.
    always_comb begin
        placed        = '0;
        placed[FB_C]  = flags_i.c;
        placed[FB_V]  = flags_i.v;
        placed[FB_Z]  = flags_i.z;
        placed[FB_N]  = flags_i.n;
        placed[FB_R]  = flags_i.r;
    end

    // Build the write mask and merge.
    always_comb begin
        wmask       = upd_mask_i;
        wmask[FB_X] = 1'b1;
        if (x_i && flags_i.z) begin
            wmask[FB_Z] = 1'b0;
        end
        ccs_o = (ccs_i & ~wmask) | (placed & wmask);
    end

    // Bits outside the caller's mask and X are never disturbed.
    always_comb begin
        AST_UNMASKED_KEPT: assert (((ccs_o ^ ccs_i) & ~upd_mask_i & ~(CCS_W'(1) << FB_X)) == '0)
            else $error("unmasked bit changed"); // R9
    end
    // Under X a computed zero never sets Z.
    always_comb begin
        AST_X_HOLDS_Z: assert (!(x_i && !ccs_i[FB_Z] && ccs_o[FB_Z])) else $error("Z set under X"); // R10
    end
endmodule

// File: rtl/ccf_eval.sv
// Condition code flag evaluator: selects the rule set for the operation
// class, merges the flags into the status word, and handles bit test.
// Purely combinational; all outputs follow the inputs in the same cycle.
module ccf_eval
    import ccf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CCS_W  = 32,
    parameter int VER_W  = 8
) (
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] mof_i,
    input  logic              x_i,
    input  logic [CCS_W-1:0]  upd_mask_i,
    input  logic [CCS_W-1:0]  ccs_i,
    input  logic [VER_W-1:0]  ver_i,
    output logic [CCS_W-1:0]  ccs_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int W1    = DATA_W + 1;

    ccf_op_e     op;
    ccf_flags_t  arith_flags, mul_flags, sel_flags;
    logic        res_sign, res_zero;
    logic        is_sub, is_mcp, narrow_move;
    logic [CCS_W-1:0] wb_ccs, bt_ccs;
    logic [IDX_W-1:0] bt_idx;
    logic [W1-1:0]    bt_span;
    logic             bt_bit, bt_zero;
    logic             unused_src;

    assign op          = ccf_op_e'(op_i);
    assign is_sub      = (op == OP_SUB);
    assign is_mcp      = (op == OP_MCP);
    assign narrow_move = (op == OP_MOVE) && (size_i == SZ_HALF || size_i == SZ_WORD);

    ccf_arith_eval #(.DATA_W(DATA_W)) u_arith (
        .src_i(src_i), .dst_i(dst_i), .res_i(res_i), .size_i(size_i),
        .is_sub_i(is_sub), .is_mcp_i(is_mcp),
        .flags_o(arith_flags), .res_sign_o(res_sign), .res_zero_o(res_zero)
    );

    ccf_mul_eval #(.DATA_W(DATA_W)) u_mul (
        .res_i(res_i), .mof_i(mof_i), .signed_i(op == OP_MULS),
        .flags_o(mul_flags)
    );

    // Choose the flag set for the operation class.
    always_comb begin
        sel_flags = arith_flags;
        if (op == OP_MULS || op == OP_MULU) begin
            sel_flags = mul_flags;
        end else if (narrow_move) begin
            sel_flags   = '0;
            sel_flags.n = res_sign;
            sel_flags.z = ~res_sign & res_zero;
        end
    end

    ccf_writeback #(.CCS_W(CCS_W)) u_wb (
        .flags_i(sel_flags), .x_i(x_i), .upd_mask_i(upd_mask_i),
        .ccs_i(ccs_i), .ccs_o(wb_ccs)
    );

    assign bt_idx     = src_i[IDX_W-1:0];
    assign unused_src = ^src_i[DATA_W-1:IDX_W];

    // Bit test: selected bit, and zero test over that bit and all below it.
    always_comb begin
        bt_span = (W1'(2) << bt_idx) - W1'(1);
        bt_bit  = dst_i[bt_idx];
        bt_zero = ~|(dst_i & bt_span[DATA_W-1:0]);
        bt_ccs  = ccs_i;
        bt_ccs[FB_X] = 1'b0;
        bt_ccs[FB_N] = bt_bit;
        bt_ccs[FB_Z] = bt_zero;
        if (ver_i < VER_W'(VER_GATE)) begin
            bt_ccs[FB_V] = 1'b0;
            bt_ccs[FB_C] = 1'b0;
        end
    end

    // Final output selection.
    always_comb begin
        ccs_o = (op == OP_BTST) ? bt_ccs : wb_ccs;
    end

    // X leaves every update cleared.
    always_comb begin
        AST_X_CLEARED: assert (!ccs_o[FB_X]) else $error("X left set"); // R9
    end
    // Bit test touches only the five low flags.
    always_comb begin
        AST_BTST_UPPER_KEPT: assert (!(op == OP_BTST) || (ccs_o[CCS_W-1:FB_X+1] == ccs_i[CCS_W-1:FB_X+1]))
            else $error("bit test changed upper bits"); // R12
    end
    // Bit test keeps V and C on new versions.
    always_comb begin
        AST_BTST_VC_NEW: assert (!(op == OP_BTST && ver_i >= VER_W'(VER_GATE)) ||
                                 (ccs_o[FB_V:FB_C] == ccs_i[FB_V:FB_C]))
            else $error("bit test changed V/C"); // R12
    end
endmodule

// File: tb/ccf_eval_tb_top.sv
// Self-checking bench: directed corners plus a seeded sweep over every
// operation class and size code, expected values from the requirement rules.
module ccf_eval_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;
    localparam int PER_COMBO  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op;
    logic [1:0]  size;
    logic [31:0] src, dst, res, mof, mask, ccs_old;
    logic        x;
    logic [7:0]  ver;
    logic [31:0] ccs_new;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccf_eval dut_i (
        .op_i(op), .size_i(size), .src_i(src), .dst_i(dst), .res_i(res),
        .mof_i(mof), .x_i(x), .upd_mask_i(mask), .ccs_i(ccs_old),
        .ver_i(ver), .ccs_o(ccs_new)
    );

    function automatic logic [31:0] model(input logic [2:0] o, input logic [1:0] sz,
            input logic [31:0] s, input logic [31:0] d, input logic [31:0] r,
            input logic [31:0] m, input logic xf, input logic [31:0] um,
            input logic [31:0] old, input logic [7:0] vr);
        logic [31:0] out;
        logic [31:0] fl;
        logic [31:0] wm;
        logic [63:0] p;
        int w;
        logic ss, ds, rs, rz, cr;
        fl = 0;
        if (o == 3'd6) begin
            out = old & ~32'h1C;
            if (vr < 8'd32) out = out & ~32'h3;
            if (d[s[4:0]]) out = out | 32'h8;
            if ((d << (31 - s[4:0])) == 0) out = out | 32'h4;
            return out;
        end
        w  = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        rs = r[w-1];
        rz = ((r << (32 - w)) == 0);
        if (o == 3'd4 || o == 3'd5) begin
            p = {m, r};
            if (p == 0) fl[2] = 1;
            if (p[63]) fl[3] = 1;
            if (o == 3'd4) fl[1] = ($signed(m) != ($signed(r) >>> 31));
            else           fl[1] = (m != 0);
        end else if (o == 3'd2 && (sz == 1 || sz == 2)) begin
            if (rs) fl[3] = 1; else if (rz) fl[2] = 1;
        end else if (sz != 3) begin
            ss = s[w-1] ^ (o == 3'd1);
            ds = d[w-1];
            if (rs) begin
                fl[3] = 1; fl[1] = !ss && !ds; cr = ss && ds;
            end else begin
                fl[2] = rz; fl[1] = ss && ds; cr = ss || ds;
            end
            if (o == 3'd3) fl[8] = cr;
            else           fl[0] = cr ^ (o == 3'd1);
        end
        wm = um | 32'h10;
        if (xf && fl[2]) wm[2] = 1'b0;
        return (old & ~wm) | (fl & wm);
    endfunction

    task automatic apply(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] s,
            input logic [31:0] d, input logic [31:0] r, input logic [31:0] m,
            input logic xf, input logic [31:0] um, input logic [31:0] old,
            input logic [7:0] vr);
        @(posedge clk);
        #1;
        op = o; size = sz; src = s; dst = d; res = r; mof = m;
        x = xf; mask = um; ccs_old = old; ver = vr;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] exp_v);
        n_vec++;
        if (ccs_new !== exp_v) begin
            n_bad++;
            $display("FAIL %s op=%0d size=%0d actual=%h expected=%h", tag, op, size, ccs_new, exp_v);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic [1:0] sz);
        case (o)
            3'd1: return "R4";
            3'd2: return (sz == 0) ? "R6_byte" : "R6";
            3'd3: return "R5";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R11";
            default: return (sz == 3) ? "R1" : "R2";
        endcase
    endfunction

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] s, d, r, m, um, old;
        void'($urandom(32'h5eed));
        op = 0; size = 0; src = 0; dst = 0; res = 0; mof = 0;
        x = 0; mask = 0; ccs_old = 0; ver = 0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Idle inputs: zero word add under full mask gives Z only (R3, R13).
        apply(3'd0, 2'd2, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0);
        check("R3", 32'h0000_0004);
        // Equal subtract: Z, no borrow; upper old bits kept (R4, R9).
        apply(3'd1, 2'd2, 5, 5, 0, 0, 0, 32'h1F, 32'hFFFF_FFFF, 0);
        check("R4", 32'hFFFF_FFE4);
        // 0 - 1: N and borrow (R4).
        apply(3'd1, 2'd2, 1, 0, 32'hFFFF_FFFF, 0, 0, 32'h1F, 0, 0);
        check("R4", 32'h0000_0009);
        // MCP with both signs set and negative result: N and R (R5, R13).
        apply(3'd3, 2'd2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'hFFFF_FFFF, 0, 0);
        check("R5", 32'h0000_0108);
        // Byte add ignores upper result bits for Z (R1).
        apply(3'd0, 2'd0, 32'h100, 32'h100, 32'hFF00, 0, 0, 32'h1F, 0, 0);
        check("R1", 32'h0000_0004);
        // X set, zero result: old Z kept, X cleared (R10).
        apply(3'd0, 2'd2, 0, 0, 0, 0, 1, 32'h1F, 32'h14, 0);
        check("R10", 32'h0000_0004);
        // X set, nonzero result: Z cleared (R10).
        apply(3'd0, 2'd2, 1, 1, 2, 0, 1, 32'h1F, 32'h14, 0);
        check("R10", 32'h0000_0000);
        // Bit test, old version: clears V/C, N from bit 4 (R11, R12).
        apply(3'd6, 2'd2, 4, 32'h10, 0, 0, 0, 0, 32'hFFFF_FFFF, 8'd10);
        check("R12", 32'hFFFF_FFE8);
        // Bit test, new version: V/C kept, bits 4..0 zero -> Z (R11, R12).
        apply(3'd6, 2'd2, 4, 32'h20, 0, 0, 0, 32'hFFFF_FFFF, 32'h3, 8'd40);
        check("R12", 32'h0000_0007);
        // Bit test of bit 31 (R11).
        apply(3'd6, 2'd2, 31, 32'h8000_0000, 0, 0, 0, 0, 0, 8'd40);
        check("R11", 32'h0000_0008);
        // Signed multiply of -1: no overflow, N (R7).
        apply(3'd4, 2'd2, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'h1F, 0, 0);
        check("R7", 32'h0000_0008);
        // Unsigned multiply with high word: V (R8).
        apply(3'd5, 2'd2, 0, 0, 0, 1, 0, 32'h1F, 0, 0);
        check("R8", 32'h0000_0002);
        // Empty mask: only X is cleared (R9).
        apply(3'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
        check("R9", 32'hFFFF_FFEF);
        // Narrow move, negative half: N only (R6).
        apply(3'd2, 2'd1, 0, 32'h8000, 32'h8000, 0, 0, 32'h1F, 0, 0);
        check("R6", 32'h0000_0008);

        // Sweep every class and size code.
        for (int o = 0; o < 8; o++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int k = 0; k < PER_COMBO; k++) begin
                    s = $urandom; d = $urandom; m = $urandom;
                    case (k % 4)
                        0: r = (o == 1) ? d - s : d + s;
                        1: r = 0;
                        2: begin s = s & 32'h8080_8080; d = d & 32'h8080_8080; r = d + s; end
                        default: r = $urandom;
                    endcase
                    if (k % 5 == 0) m = 0;
                    if (k % 5 == 1) m = {32{r[31]}};
                    if (o == 6 && (k % 3 == 0)) d = 32'h1 << (k % 32);
                    um  = (k % 2 == 0) ? 32'h0000_011F : $urandom;
                    old = $urandom;
                    apply(o[2:0], sz[1:0], s, d, r, m, k[0] ^ k[2], um, old, $urandom);
                    check(tag_of(o[2:0], sz[1:0]),
                          model(o[2:0], sz[1:0], s, d, r, m, k[0] ^ k[2], um, old, ver));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule